// File: doc/BRIEF.md
# Trace Record Funnel

The funnel merges record streams from several trace capture agents into one output stream for an export port. Each input and the output are valid/ready beat streams carrying a start-of-record flag and an end-of-record flag. A record is one beat (short form) or several beats (long form). The funnel forwards whole records one at a time and never mixes beats of two records on the output.

Configuration inputs select which sources take part in the trace and give each source a priority level. A source whose start beat is waiting competes only when the funnel is idle. The highest level wins, and equal levels share service through a rotating pointer. A disabled source is drained so that it can never block its agent. Each forwarded record has its source number written into the top bits of its first beat, so the records can be separated again after capture. A global stall input freezes both sides of the funnel so that no beat is lost.

The path from input to output has no register. A granted beat therefore appears on the output in the same cycle that it is offered.

Top module: `trace_funnel`

## Requirements
- R1: Every beat that an enabled source hands over is forwarded exactly once, in that source's order, and all of its bits pass through unchanged except the tag field described in R2.
- R2: On the first beat of each forwarded record, bits [DATA_W-1 -: TAG_W] (bits 31:30 by default) carry the index of the source. All later beats of the record keep those bits as the source drove them.
- R3: Once a start beat is accepted without an end flag, only that source's beats reach the output until its end beat is accepted. While this is happening, no other enabled source sees ready on a start beat.
- R4: When idle, among enabled sources presenting a start beat, the one with the numerically largest priority (src_prio, PRIO_W bits per source) is served first.
- R5: Among sources of equal priority, the search starts at the source after the one granted last and wraps around, so service rotates.
- R6: While stall is high, out_valid is low and every src_ready bit is low.
- R7: A source whose src_enable bit is 0 sees src_ready high when not stalled, and none of its records reaches the output.
- R8: Records of one beat and of several beats are both forwarded. out_eop marks the last beat, and a granted beat appears on the output in the cycle it is offered.
- R9: A beat without the start flag, from an enabled source that does not own the output, is discarded: its ready is high and it is not forwarded.
- R10: After reset the funnel is idle, the rotation starts at source 0, and out_valid is low while no source is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Freezes input and output handshakes |
| src_enable | input | NUM_SRC | Per-source trace inclusion mask |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority level, larger wins |
| src_valid | input | NUM_SRC | Per-source beat valid |
| src_ready | output | NUM_SRC | Per-source beat ready |
| src_data | input | NUM_SRC*DATA_W | Per-source beat payload |
| src_sop | input | NUM_SRC | Per-source start-of-record flag |
| src_eop | input | NUM_SRC | Per-source end-of-record flag |
| out_valid | output | 1 | Merged beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Merged beat payload, tagged on the first beat |
| out_sop | output | 1 | Merged start-of-record flag |
| out_eop | output | 1 | Merged end-of-record flag |

## Verification
The bench uses the defaults: four sources, 32-bit beats and 2-bit priorities. With only four priority levels across four sources, random priority settings often tie. As a result, both the priority order and the rotation decide grants within one run. Two-bit tags fill the index range exactly, so a wrong tag always names a different real source. Records of one to four beats, random downstream back-pressure, random stalls and a partly disabled mask bring a lock held across stalls, drained disabled sources and tie rotation within reach.

// File: rtl/trace_funnel_pkg.sv
package trace_funnel_pkg;

   typedef enum logic {
      FN_IDLE   = 1'b0,
      FN_LOCKED = 1'b1
   } fn_state_e;

   // index that follows cur in a ring of n entries
   function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/trace_funnel_arb.sv
module trace_funnel_arb #(
   parameter int NUM_SRC     = 4,
   parameter int PRIO_W      = 2,
   parameter int IDX_W       = 2,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   input  logic [IDX_W-1:0]          rr_ptr,
   output logic                      grant_vld,
   output logic [IDX_W-1:0]          grant_idx
);

   logic [PRIO_W-1:0] lvl [NUM_SRC];
   logic [IDX_W-1:0]  scan_start;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
      assign lvl[g] = prio[g*PRIO_W +: PRIO_W];
   end

   if (ROUND_ROBIN) begin : g_rotate
      assign scan_start = rr_ptr;
   end else begin : g_fixed
      assign scan_start = '0;
   end

   logic [PRIO_W-1:0] best_lvl;

   always_comb begin
      int idx;
      grant_vld = 1'b0;
      grant_idx = '0;
      best_lvl  = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         idx = (int'(scan_start) + k) % NUM_SRC;
         if (req[idx] && (!grant_vld || lvl[idx] > best_lvl)) begin
            grant_vld = 1'b1;
            grant_idx = IDX_W'(idx);
            best_lvl  = lvl[idx];
         end
      end
   end

   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> req[grant_idx]);                                   // R4
   AST_REQ_GETS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> grant_vld);                                      // R4

endmodule

// File: rtl/trace_funnel_mux.sv
module trace_funnel_mux #(
   parameter int NUM_SRC    = 4,
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 2,
   parameter bit TAG_INSERT = 1'b1
) (
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   input  logic [NUM_SRC-1:0]        src_sop,
   input  logic [NUM_SRC-1:0]        src_eop,
   input  logic [NUM_SRC-1:0]        src_valid,
   input  logic [IDX_W-1:0]          sel,
   input  logic                      tag_en,
   output logic [DATA_W-1:0]         beat_data,
   output logic                      beat_sop,
   output logic                      beat_eop,
   output logic                      beat_valid
);

   logic [DATA_W-1:0] word [NUM_SRC];
   logic [DATA_W-1:0] raw;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_word
      assign word[g] = src_data[g*DATA_W +: DATA_W];
   end

   assign raw        = word[sel];
   assign beat_sop   = src_sop[sel];
   assign beat_eop   = src_eop[sel];
   assign beat_valid = src_valid[sel];

   if (TAG_INSERT) begin : g_tag
      always_comb begin
         beat_data = raw;
         if (tag_en) beat_data[DATA_W-1 -: IDX_W] = sel;
      end
   end else begin : g_notag
      assign beat_data = raw;
   end

endmodule

// File: rtl/trace_funnel.sv
module trace_funnel
   import trace_funnel_pkg::*;
#(
   parameter int NUM_SRC     = 4,
   parameter int DATA_W      = 32,
   parameter int PRIO_W      = 2,
   parameter bit ROUND_ROBIN = 1'b1,
   parameter bit TAG_INSERT  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      stall,
   input  logic [NUM_SRC-1:0]        src_enable,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input  logic [NUM_SRC-1:0]        src_valid,
   output logic [NUM_SRC-1:0]        src_ready,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   input  logic [NUM_SRC-1:0]        src_sop,
   input  logic [NUM_SRC-1:0]        src_eop,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [DATA_W-1:0]         out_data,
   output logic                      out_sop,
   output logic                      out_eop
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("trace_funnel: NUM_SRC must be at least 2");
   end
   if (DATA_W <= IDX_W) begin : g_bad_width
      $error("trace_funnel: DATA_W must exceed the tag width");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("trace_funnel: PRIO_W must be at least 1");
   end

   fn_state_e         state;
   logic [IDX_W-1:0]  owner;
   logic [IDX_W-1:0]  rr_ptr;
   logic [NUM_SRC-1:0] start_req;
   logic               g_vld;
   logic [IDX_W-1:0]   g_idx;
   logic [IDX_W-1:0]   sel;
   logic               busy;
   logic               m_valid;
   logic               accept;

   assign busy      = (state == FN_LOCKED);
   assign start_req = src_enable & src_valid & src_sop;

   trace_funnel_arb #(
      .NUM_SRC     (NUM_SRC),
      .PRIO_W      (PRIO_W),
      .IDX_W       (IDX_W),
      .ROUND_ROBIN (ROUND_ROBIN)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (start_req),
      .prio      (src_prio),
      .rr_ptr    (rr_ptr),
      .grant_vld (g_vld),
      .grant_idx (g_idx)
   );

   assign sel = busy ? owner : g_idx;

   trace_funnel_mux #(
      .NUM_SRC    (NUM_SRC),
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W),
      .TAG_INSERT (TAG_INSERT)
   ) u_mux (
      .src_data   (src_data),
      .src_sop    (src_sop),
      .src_eop    (src_eop),
      .src_valid  (src_valid),
      .sel        (sel),
      .tag_en     (!busy),
      .beat_data  (out_data),
      .beat_sop   (out_sop),
      .beat_eop   (out_eop),
      .beat_valid (m_valid)
   );

   assign out_valid = !stall && (busy ? m_valid : g_vld);
   assign accept    = out_valid && out_ready;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         if (stall)                                    src_ready[i] = 1'b0;
         else if (busy && owner == IDX_W'(i))          src_ready[i] = out_ready;
         else if (!busy && g_vld && g_idx == IDX_W'(i)) src_ready[i] = out_ready;
         else if (!src_enable[i])                      src_ready[i] = 1'b1;
         else if (src_valid[i] && !src_sop[i])         src_ready[i] = 1'b1;
         else                                          src_ready[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= FN_IDLE;
         owner  <= '0;
         rr_ptr <= '0;
      end else if (accept) begin
         if (!busy) begin
            rr_ptr <= IDX_W'(ring_next(int'(g_idx), NUM_SRC));
            owner  <= g_idx;
            if (!out_eop) state <= FN_LOCKED;
         end else if (out_eop) begin
            state <= FN_IDLE;
         end
      end
   end

   AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!out_valid && src_ready == '0));                       // R6
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(accept && out_eop)) |=> (busy && owner == $past(owner))); // R3
   AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !busy) |-> out_sop);                                // R3
   AST_FWD_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (src_valid[sel] && src_ready[sel]));                   // R1
   AST_OPEN_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && out_sop && !out_eop) |=> busy);                        // R8

endmodule

// File: tb/tb_trace_funnel.sv
module tb_trace_funnel;

   localparam int NS   = 4;
   localparam int DW   = 32;
   localparam int PW   = 2;
   localparam int RECS = 40;

   logic clk = 1'b0;
   logic rst_n;
   logic stall;
   logic [NS-1:0]    en, s_valid, s_ready, s_sop, s_eop;
   logic [NS*PW-1:0] prio;
   logic [NS*DW-1:0] s_data;
   logic             o_valid, o_ready, o_sop, o_eop;
   logic [DW-1:0]    o_data;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   trace_funnel dut (
      .clk(clk), .rst_n(rst_n), .stall(stall), .src_enable(en), .src_prio(prio),
      .src_valid(s_valid), .src_ready(s_ready), .src_data(s_data),
      .src_sop(s_sop), .src_eop(s_eop), .out_valid(o_valid), .out_ready(o_ready),
      .out_data(o_data), .out_sop(o_sop), .out_eop(o_eop)
   );

   function automatic int rec_len(int s, int r);
      return ((r * 5 + s * 3) % 4) + 1;
   endfunction

   function automatic logic [DW-1:0] beat_word(int s, int r, int b);
      logic [1:0] junk;
      junk = 2'((r + b + s * 3) & 3);
      return {junk, 6'(s), 16'(r), 8'(b)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; stall = 1'b0; en = '1; prio = '0;
      s_valid = '0; s_sop = '0; s_eop = '0; s_data = '0; o_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put(int s, int r, int b, bit v);
      s_valid[s] = v;
      s_sop[s]   = (b == 0);
      s_eop[s]   = (b == rec_len(s, r) - 1);
      s_data[s*DW +: DW] = beat_word(s, r, b);
   endtask

   // random phase state
   int  cur_rec [NS];
   int  cur_beat[NS];
   int  exp_rec [NS];
   int  exp_beat[NS];

   task automatic random_phase(input logic [NS-1:0] mask);
      bit in_rec = 0;
      int owner  = 0;
      int cyc    = 0;
      bit done;
      en = mask;
      for (int i = 0; i < NS; i++) begin
         cur_rec[i] = 0; cur_beat[i] = 0; exp_rec[i] = 0; exp_beat[i] = 0;
         prio[i*PW +: PW] = PW'($urandom % 4);
         put(i, 0, 0, 1'b0);
      end
      do begin
         stall   = ($urandom % 8 == 0);
         o_ready = ($urandom % 4 != 0);
         #1;
         if (stall) begin
            chk(!o_valid && s_ready == '0, "R6", "stall quiets both sides",
                {o_valid, 4'(s_ready)}, 0);
         end
         for (int i = 0; i < NS; i++) begin
            if (!stall && !en[i] && s_valid[i])
               chk(s_ready[i], "R7", "disabled source ready", s_ready[i], 1);
         end
         if (o_valid && o_ready) begin
            if (o_sop) begin
               int s;
               s = int'(o_data[DW-1 -: 2]);
               chk(!in_rec, "R3", "start beat inside open record", in_rec, 0);
               chk(en[s], "R7", "record from disabled source", s, 0);
               chk(o_data[DW-3:0] == beat_word(s, exp_rec[s], 0)[DW-3:0], "R1",
                   "first beat payload", o_data, beat_word(s, exp_rec[s], 0));
               owner = s;
               exp_beat[s] = 0;
            end else begin
               chk(in_rec, "R9", "beat outside record", in_rec, 1);
               chk(o_data == beat_word(owner, exp_rec[owner], exp_beat[owner]), "R2",
                   "later beat unchanged", o_data,
                   beat_word(owner, exp_rec[owner], exp_beat[owner]));
            end
            chk(o_eop == (exp_beat[owner] == rec_len(owner, exp_rec[owner]) - 1), "R8",
                "end flag position", o_eop, exp_beat[owner]);
            if (o_eop) begin
               in_rec = 0;
               exp_rec[owner]++;
               exp_beat[owner] = 0;
            end else begin
               in_rec = 1;
               exp_beat[owner]++;
            end
         end
         for (int i = 0; i < NS; i++) begin
            if (s_valid[i] && s_ready[i]) begin
               cur_beat[i]++;
               if (cur_beat[i] == rec_len(i, cur_rec[i])) begin
                  cur_rec[i]++; cur_beat[i] = 0;
               end
            end
         end
         @(negedge clk);
         for (int i = 0; i < NS; i++) begin
            bit v;
            v = s_valid[i] && !s_ready[i];
            if (!v) v = (cur_rec[i] < RECS) && ($urandom % 2 == 1);
            put(i, cur_rec[i], cur_beat[i], v);
         end
         done = 1;
         for (int i = 0; i < NS; i++) if (cur_rec[i] < RECS || s_valid[i]) done = 0;
         cyc++;
      end while (!done && cyc < 20000);
      stall = 1'b0;
      for (int i = 0; i < NS; i++) begin
         if (en[i])
            chk(exp_rec[i] == RECS, "R1", "records delivered per source", exp_rec[i], RECS);
         else
            chk(exp_rec[i] == 0, "R7", "disabled source delivered nothing", exp_rec[i], 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int order [4];
      void'($urandom(32'd20240611));
      do_reset();

      // R10: idle after reset
      #1;
      chk(!o_valid, "R10", "out_valid after reset", o_valid, 0);
      @(negedge clk);

      // R4 and R8: one-beat records, distinct priorities, zero latency
      prio = {2'd0, 2'd2, 2'd3, 2'd1};
      for (int i = 0; i < NS; i++) begin
         s_valid[i] = 1'b1; s_sop[i] = 1'b1; s_eop[i] = 1'b1;
         s_data[i*DW +: DW] = beat_word(i, 0, 0);
      end
      order = '{1, 2, 0, 3};
      for (int k = 0; k < 4; k++) begin
         #1;
         chk(o_valid && o_sop && o_eop, "R8", "one-beat record offered at once",
             {o_valid, o_sop, o_eop}, 3'b111);
         chk(o_data[DW-1 -: 2] == 2'(order[k]), "R4", "priority order tag",
             o_data[DW-1 -: 2], order[k]);
         @(negedge clk);
         s_valid[order[k]] = 1'b0;
      end

      // R5 and R10: equal priorities rotate starting at source 0
      do_reset();
      for (int i = 0; i < NS; i++) begin
         s_valid[i] = 1'b1; s_sop[i] = 1'b1; s_eop[i] = 1'b1;
         s_data[i*DW +: DW] = beat_word(i, 0, 0);
      end
      for (int k = 0; k < 8; k++) begin
         #1;
         chk(o_data[DW-1 -: 2] == 2'(k % 4), "R5", "rotation order",
             o_data[DW-1 -: 2], k % 4);
         @(negedge clk);
      end

      // R3: a higher priority start waits until the open record ends
      do_reset();
      prio = {2'd0, 2'd0, 2'd3, 2'd0};
      s_valid[0] = 1'b1; s_sop[0] = 1'b1; s_eop[0] = 1'b0;
      s_data[0 +: DW] = beat_word(0, 9, 0);
      #1;
      chk(o_valid && o_data[DW-1 -: 2] == 2'd0, "R2", "tag of long record",
          o_data[DW-1 -: 2], 0);
      @(negedge clk);
      s_sop[0] = 1'b0; s_data[0 +: DW] = beat_word(0, 9, 1);
      s_valid[1] = 1'b1; s_sop[1] = 1'b1; s_eop[1] = 1'b1;
      s_data[DW +: DW] = beat_word(1, 0, 0);
      #1;
      chk(o_data == beat_word(0, 9, 1) && !o_sop, "R3", "second beat stays with owner",
          o_data, beat_word(0, 9, 1));
      chk(!s_ready[1], "R3", "other start held back", s_ready[1], 0);
      @(negedge clk);
      s_eop[0] = 1'b1; s_data[0 +: DW] = beat_word(0, 9, 2);
      #1;
      chk(o_eop && o_data == beat_word(0, 9, 2), "R8", "last beat of long record",
          o_data, beat_word(0, 9, 2));
      @(negedge clk);
      s_valid[0] = 1'b0;
      #1;
      chk(o_valid && o_data[DW-1 -: 2] == 2'd1, "R3", "waiting start served after end",
          o_data[DW-1 -: 2], 1);
      @(negedge clk);
      s_valid = '0;

      // R7: disabled source drained and not forwarded
      do_reset();
      en = 4'b1011;
      s_valid[2] = 1'b1; s_sop[2] = 1'b1; s_eop[2] = 1'b1;
      #1;
      chk(s_ready[2] && !o_valid, "R7", "disabled source drained",
          {s_ready[2], o_valid}, 2'b10);
      @(negedge clk);

      // R9: stray non-start beat discarded
      do_reset();
      s_valid[0] = 1'b1; s_sop[0] = 1'b0; s_eop[0] = 1'b0;
      #1;
      chk(s_ready[0] && !o_valid, "R9", "stray beat discarded",
          {s_ready[0], o_valid}, 2'b10);
      @(negedge clk);

      // R6: stall with all sources waiting
      do_reset();
      stall = 1'b1;
      s_valid = '1; s_sop = '1; s_eop = '1;
      #1;
      chk(!o_valid && s_ready == '0, "R6", "stall blocks all",
          {o_valid, 4'(s_ready)}, 0);
      @(negedge clk);
      stall = 1'b0;
      #1;
      chk(o_valid, "R6", "release after stall", o_valid, 1);
      @(negedge clk);

      // random phases: all enabled, then a partial mask
      do_reset();
      random_phase(4'b1111);
      do_reset();
      random_phase(4'b1011);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule